// File: doc/BRIEF.md
# Buffered-Program Load Sequencer

This block runs the buffered-program command of a NOR-style flash controller once an upstream decoder has seen the two unlock writes and the buffer-load command code. The decoder marks that write with `begin_i`, and the block records the sector address carried by it. The next write is the count write. Its address must name the same sector, and its data is the number of words to load, minus one. The block then accepts exactly that many address/data loads into a small word buffer. The buffer slot comes from the low address bits, and a repeated slot overwrites the earlier word.

After the last load the block waits for one confirm write to the sector. When the confirm arrives it pulses `start_o` and presents the page base address and a mask of loaded slots. The programming engine reads the stored words through a read port. The block stays busy until the engine raises `done_i`.

Any illegal write sends the block into a sticky abort state. A write outside the page, a sector mismatch, an oversized count or a wrong confirm all do this. Only the full three-write exit sequence takes the block out of that state.

Top module: `wbl_seq`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block returns to idle. After reset, `busy_o`, `abort_o` and `start_o` are 0 and no slot is marked in `mask_o`.
- R2: In idle, a write with `begin_i`=1 records the sector, which is the address bits at and above bit 16. The following write is the count write. If its sector differs, or its data is larger than DEPTH-1 (31), the block aborts. Otherwise count+1 loads are expected.
- R3: The block accepts exactly count+1 loads. Each load stores its data in the slot given by address bits [4:0] and sets that slot's bit in `mask_o`. A repeated slot keeps the latest data. The mask is cleared when a new command begins.
- R4: Every load after the first must have the same page as the first load, where the page is the address bits at and above bit 5. A load from another page aborts.
- R5: The first load must lie in the recorded sector, or the block aborts.
- R6: After the last load, a write whose data low byte is 0x29 to the recorded sector raises `start_o` for exactly one cycle and sets `busy_o`. From that point `base_o` is the page address with bits [4:0] zero, and `rd_data_o` returns the word stored at slot `rd_idx_i`.
- R7: After the last load, any other write aborts the block. This includes a wrong data code and a 0x29 to another sector.
- R8: `abort_o` stays high, and `begin_i` and other writes are ignored, until the three writes 0xAA at 0x555, 0x55 at 0x2AA and 0xF0 at 0x555 arrive in order. Only address bits [10:0] and data bits [7:0] are compared. A lone 0xF0 write or a broken sequence does not clear the abort. After the third write the block is idle.
- R9: While busy, writes and `begin_i` are ignored and `mask_o` is held. `done_i` returns the block to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en_i | input | 1 | Bus write strobe, one cycle per write |
| wr_addr_i | input | ADDR_W | Word address of the write |
| wr_data_i | input | DATA_W | Write data |
| begin_i | input | 1 | Marks the buffer-load command write (upstream decode) |
| done_i | input | 1 | Programming engine finished |
| rd_idx_i | input | log2(DEPTH) | Buffer slot read by the engine |
| rd_data_o | output | DATA_W | Word stored at `rd_idx_i` |
| start_o | output | 1 | One-cycle start pulse to the engine |
| base_o | output | ADDR_W | Page base address |
| mask_o | output | DEPTH | Loaded-slot mask |
| busy_o | output | 1 | Handoff in progress |
| abort_o | output | 1 | Sticky abort state |

## Verification
The bound checker watches several properties on every cycle:
- `start_o` is a single-cycle pulse, and it only appears together with `busy_o`.
- `busy_o` and `abort_o` are never high at the same time.
- Busy holds until `done_i`, and the mask stays frozen while busy.
- Abort persists through idle cycles.

Some behaviours depend on the data and address history, so only the bench scenarios can show them:
- exact load counting and overwrite of a repeated slot;
- page and sector rejection;
- the count limit at 31 versus 32;
- the exact exit sequence, including the broken and lone-exit cases.

// File: rtl/wbl_pkg.sv
// Shared types and bus codes for the buffered-program load sequencer.
// Assumes x16 word addressing; command codes sit in data bits [7:0].
package wbl_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_COUNT,
        ST_LOAD,
        ST_CONFIRM,
        ST_BUSY,
        ST_ABORT
    } wbl_state_e;

    localparam logic [7:0]  CODE_CONFIRM = 8'h29;
    localparam logic [7:0]  CODE_KEY1    = 8'hAA;
    localparam logic [7:0]  CODE_KEY2    = 8'h55;
    localparam logic [7:0]  CODE_EXIT    = 8'hF0;
    localparam logic [10:0] ADR_KEY1     = 11'h555;
    localparam logic [10:0] ADR_KEY2     = 11'h2AA;
endpackage

// File: rtl/wbl_exit_match.sv
// Recognises the three-write abort exit sequence (R8).
// Assumes only address bits [10:0] and data bits [7:0] are decoded.
// The matcher is active only while armed is high; otherwise it stays at step 0.
module wbl_exit_match
    import wbl_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        armed,
    input  logic        wr_en,
    input  logic [10:0] adr_lo,
    input  logic [7:0]  dat_lo,
    output logic        hit
);
    logic [1:0] step_q;
    logic       is_key1, is_key2, is_exit;

    // Classify the current write against the three expected writes
    always_comb begin
        is_key1 = (adr_lo == ADR_KEY1) && (dat_lo == CODE_KEY1);
        is_key2 = (adr_lo == ADR_KEY2) && (dat_lo == CODE_KEY2);
        is_exit = (adr_lo == ADR_KEY1) && (dat_lo == CODE_EXIT);
        hit     = armed && wr_en && (step_q == 2'd2) && is_exit;
    end

    // Advance on a matching write, restart on anything else
    always_ff @(posedge clk) begin
        if (!rst_n || !armed) begin
            step_q <= 2'd0;
        end else if (wr_en) begin
            if (hit)                               step_q <= 2'd0;
            else if ((step_q == 2'd1) && is_key2)  step_q <= 2'd2;
            else if (is_key1)                      step_q <= 2'd1;
            else                                   step_q <= 2'd0;
        end
    end
endmodule

// File: rtl/wbl_store.sv
// Word buffer with a loaded-slot mask (R3, R6).
// Data words are not reset; the mask tells which slots hold valid data.
module wbl_store #(
    parameter int DEPTH  = 32,
    parameter int DATA_W = 16,
    parameter int IDX_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              we,
    input  logic [IDX_W-1:0]  idx,
    input  logic [DATA_W-1:0] wdata,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_data,
    output logic [DEPTH-1:0]  mask
);
    logic [DATA_W-1:0] mem [DEPTH];

    // Store each accepted load; a repeated slot is overwritten
    always_ff @(posedge clk) begin
        if (we) mem[idx] <= wdata;
    end

    // Track which slots were loaded since the command began
    always_ff @(posedge clk) begin
        if (!rst_n || clr) mask <= '0;
        else if (we)       mask[idx] <= 1'b1;
    end

    // Read port for the programming engine
    assign rd_data = mem[rd_idx];
endmodule

// File: rtl/wbl_ctrl.sv
// Control FSM: sector capture, count check, page check, confirm, handoff, abort.
// Assumes SECT_LSB >= IDX_W, so a page never spans two sectors.
module wbl_ctrl
    import wbl_pkg::*;
#(
    parameter int ADDR_W   = 23,
    parameter int DATA_W   = 16,
    parameter int DEPTH    = 32,
    parameter int SECT_LSB = 16,
    parameter int IDX_W    = 5
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   wr_addr,
    input  logic [DATA_W-1:0]   wr_data,
    input  logic                begin_i,
    input  logic                done_i,
    input  logic                exit_hit,
    output wbl_state_e          state,
    output logic                store_clr,
    output logic                store_we,
    output logic                start,
    output logic [ADDR_W-1:0]   base
);
    localparam int SECT_W = ADDR_W - SECT_LSB;
    localparam int PAGE_W = ADDR_W - IDX_W;

    logic [SECT_W-1:0] sect_q;
    logic [PAGE_W-1:0] page_q;
    logic [IDX_W-1:0]  remain_q;
    logic              first_q;
    logic              sect_hit, page_hit, count_ok, load_ok, is_confirm;

    // Decode the current write against the captured context
    always_comb begin
        sect_hit   = (wr_addr[ADDR_W-1:SECT_LSB] == sect_q);
        page_hit   = (wr_addr[ADDR_W-1:IDX_W] == page_q);
        count_ok   = (wr_data <= DATA_W'(DEPTH - 1));
        load_ok    = first_q ? sect_hit : page_hit;
        is_confirm = sect_hit && (wr_data[7:0] == CODE_CONFIRM);
        store_clr  = (state == ST_IDLE) && wr_en && begin_i;
        store_we   = (state == ST_LOAD) && wr_en && load_ok;
    end

    assign base = {page_q, {IDX_W{1'b0}}};

    // Sequence state, counters and the start pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            sect_q   <= '0;
            page_q   <= '0;
            remain_q <= '0;
            first_q  <= 1'b0;
            start    <= 1'b0;
        end else begin
            start <= 1'b0;
            unique case (state)
                ST_IDLE: if (wr_en && begin_i) begin
                    sect_q <= wr_addr[ADDR_W-1:SECT_LSB];
                    state  <= ST_COUNT;
                end
                ST_COUNT: if (wr_en) begin
                    if (sect_hit && count_ok) begin
                        remain_q <= wr_data[IDX_W-1:0];
                        first_q  <= 1'b1;
                        state    <= ST_LOAD;
                    end else begin
                        state <= ST_ABORT;
                    end
                end
                ST_LOAD: if (wr_en) begin
                    if (load_ok) begin
                        first_q <= 1'b0;
                        if (first_q) page_q <= wr_addr[ADDR_W-1:IDX_W];
                        if (remain_q == '0) state <= ST_CONFIRM;
                        else                remain_q <= remain_q - 1'b1;
                    end else begin
                        state <= ST_ABORT;
                    end
                end
                ST_CONFIRM: if (wr_en) begin
                    if (is_confirm) begin
                        start <= 1'b1;
                        state <= ST_BUSY;
                    end else begin
                        state <= ST_ABORT;
                    end
                end
                ST_BUSY:  if (done_i)   state <= ST_IDLE;
                ST_ABORT: if (exit_hit) state <= ST_IDLE;
                default:  state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/wbl_seq.sv
// Top of the buffered-program load sequencer.
// Assumes begin_i is raised by an upstream decoder on the command write
// that follows the unlock pair. Writes are single-cycle strobes.
module wbl_seq
    import wbl_pkg::*;
#(
    parameter int ADDR_W   = 23,
    parameter int DATA_W   = 16,
    parameter int DEPTH    = 32,
    parameter int SECT_LSB = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en_i,
    input  logic [ADDR_W-1:0]        wr_addr_i,
    input  logic [DATA_W-1:0]        wr_data_i,
    input  logic                     begin_i,
    input  logic                     done_i,
    input  logic [$clog2(DEPTH)-1:0] rd_idx_i,
    output logic [DATA_W-1:0]        rd_data_o,
    output logic                     start_o,
    output logic [ADDR_W-1:0]        base_o,
    output logic [DEPTH-1:0]         mask_o,
    output logic                     busy_o,
    output logic                     abort_o
);
    localparam int IDX_W = $clog2(DEPTH);

    wbl_state_e state;
    logic       store_clr, store_we, exit_hit;

    wbl_ctrl #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(DEPTH),
        .SECT_LSB(SECT_LSB), .IDX_W(IDX_W)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en_i), .wr_addr(wr_addr_i),
        .wr_data(wr_data_i), .begin_i(begin_i), .done_i(done_i),
        .exit_hit(exit_hit), .state(state), .store_clr(store_clr),
        .store_we(store_we), .start(start_o), .base(base_o)
    );

    wbl_store #(.DEPTH(DEPTH), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_store (
        .clk(clk), .rst_n(rst_n), .clr(store_clr), .we(store_we),
        .idx(wr_addr_i[IDX_W-1:0]), .wdata(wr_data_i),
        .rd_idx(rd_idx_i), .rd_data(rd_data_o), .mask(mask_o)
    );

    wbl_exit_match u_exit (
        .clk(clk), .rst_n(rst_n), .armed(state == ST_ABORT),
        .wr_en(wr_en_i), .adr_lo(wr_addr_i[10:0]), .dat_lo(wr_data_i[7:0]),
        .hit(exit_hit)
    );

    assign busy_o  = (state == ST_BUSY);
    assign abort_o = (state == ST_ABORT);
endmodule

// File: rtl/wbl_seq_chk.sv
// Port-level properties of wbl_seq, attached by bind.
module wbl_seq_chk #(
    parameter int ADDR_W = 23,
    parameter int DEPTH  = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en_i,
    input logic              done_i,
    input logic              start_o,
    input logic [DEPTH-1:0]  mask_o,
    input logic              busy_o,
    input logic              abort_o
);
    p_start_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        start_o |=> !start_o);
    p_start_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
        start_o |-> (busy_o && !abort_o));
    p_start_mask_r3: assert property (@(posedge clk) disable iff (!rst_n)
        start_o |-> ($countones(mask_o) > 0));
    p_busy_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !done_i) |=> busy_o);
    p_mask_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && $past(busy_o)) |-> $stable(mask_o));
    p_abort_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (abort_o && !wr_en_i) |=> abort_o);
    p_abort_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(abort_o && busy_o));
    p_abort_nostart_r8: assert property (@(posedge clk) disable iff (!rst_n)
        abort_o |=> !start_o);
endmodule

bind wbl_seq wbl_seq_chk #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) i_chk (
    .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en_i), .done_i(done_i),
    .start_o(start_o), .mask_o(mask_o), .busy_o(busy_o), .abort_o(abort_o)
);

// File: tb/test_wbl_seq.sv
`timescale 1ns/1ps
module test_wbl_seq;
    localparam int AW = 23;
    localparam int DW = 16;
    localparam int DEPTH = 32;

    typedef struct packed {
        logic          beg;
        logic [AW-1:0] addr;
        logic [DW-1:0] data;
        logic          ab;
        logic          bz;
        logic          st;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VEC [NV] = '{
        '{1'b1, 23'h020000, 16'h0025, 1'b0, 1'b0, 1'b0},
        '{1'b0, 23'h020000, 16'h0001, 1'b0, 1'b0, 1'b0},
        '{1'b0, 23'h020100, 16'hAAAA, 1'b0, 1'b0, 1'b0},
        '{1'b0, 23'h020120, 16'hBBBB, 1'b1, 1'b0, 1'b0},
        '{1'b1, 23'h000555, 16'h00F0, 1'b1, 1'b0, 1'b0},
        '{1'b0, 23'h000555, 16'h00AA, 1'b1, 1'b0, 1'b0},
        '{1'b0, 23'h0002AA, 16'h0055, 1'b1, 1'b0, 1'b0},
        '{1'b0, 23'h000555, 16'h00F0, 1'b0, 1'b0, 1'b0},
        '{1'b1, 23'h050000, 16'h0025, 1'b0, 1'b0, 1'b0},
        '{1'b0, 23'h050000, 16'h0002, 1'b0, 1'b0, 1'b0},
        '{1'b0, 23'h050043, 16'h1111, 1'b0, 1'b0, 1'b0},
        '{1'b0, 23'h050047, 16'h2222, 1'b0, 1'b0, 1'b0},
        '{1'b0, 23'h050043, 16'h3333, 1'b0, 1'b0, 1'b0},
        '{1'b0, 23'h050000, 16'h0029, 1'b0, 1'b1, 1'b1}
    };

    logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, beg = 1'b0, done = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] data = '0;
    logic [4:0] rd_idx = '0;
    logic [DW-1:0] rd_data;
    logic start, busy, abort;
    logic [AW-1:0] base;
    logic [DEPTH-1:0] mask;
    int errors = 0, checks = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    wbl_seq i_wbl_seq (
        .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .wr_addr_i(addr),
        .wr_data_i(data), .begin_i(beg), .done_i(done), .rd_idx_i(rd_idx),
        .rd_data_o(rd_data), .start_o(start), .base_o(base), .mask_o(mask),
        .busy_o(busy), .abort_o(abort)
    );

    task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got=%0h exp=%0h", req, got, exp);
        end
    endtask

    // One write; returns at the falling edge after the capturing edge
    task automatic wr(input logic b, input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        wr_en = 1'b1; beg = b; addr = a; data = d;
        @(negedge clk);
        wr_en = 1'b0; beg = 1'b0;
    endtask

    task automatic finish_busy();
        @(negedge clk); done = 1'b1;
        @(negedge clk); done = 1'b0;
    endtask

    task automatic recover();
        wr(0, 23'h000555, 16'h00AA);
        wr(0, 23'h0002AA, 16'h0055);
        wr(0, 23'h000555, 16'h00F0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 busy", busy, 0); chk("R1 abort", abort, 0);
        chk("R1 start", start, 0); chk("R1 mask", mask, 0);
        rst_n = 1'b1;

        // Table: page abort, exit sequence, then a normal three-word load (R4, R8, R3, R6)
        for (int i = 0; i < NV; i++) begin
            wr(VEC[i].beg, VEC[i].addr, VEC[i].data);
            chk($sformatf("R4/R8/R6 row%0d abort", i), abort, VEC[i].ab);
            chk($sformatf("R3/R6 row%0d busy", i), busy, VEC[i].bz);
            chk($sformatf("R6 row%0d start", i), start, VEC[i].st);
        end
        @(negedge clk);
        chk("R6 start one cycle", start, 0);
        chk("R3 mask slots 3,7", mask, 64'h88);
        chk("R6 base", base, 23'h050040);
        rd_idx = 5'd3; #1 chk("R3 overwrite slot3", rd_data, 16'h3333);
        rd_idx = 5'd7; #1 chk("R6 slot7", rd_data, 16'h2222);

        // R9: writes and begin ignored while busy
        wr(1, 23'h050000, 16'h0025);
        wr(0, 23'h050041, 16'h9999);
        chk("R9 still busy", busy, 1); chk("R9 mask held", mask, 64'h88);
        chk("R9 no abort", abort, 0);
        rd_idx = 5'd1; #1 chk("R9 slot1 mask only", mask[1], 0);
        finish_busy();
        chk("R9 idle after done", busy, 0);

        // R2/R3 boundary: count 31 fills all slots
        wr(1, 23'h010000, 16'h0025);
        wr(0, 23'h010000, 16'd31);
        for (int k = 0; k < 32; k++) wr(0, 23'h010000 + k, 16'(k * 3));
        chk("R3 no early busy", busy, 0);
        wr(0, 23'h010000, 16'h0029);
        chk("R2 full start", start, 1);
        chk("R3 full mask", mask, 64'hFFFF_FFFF);
        rd_idx = 5'd31; #1 chk("R3 slot31", rd_data, 16'd93);
        finish_busy();

        // R2: count 32 aborts
        wr(1, 23'h010000, 16'h0025);
        wr(0, 23'h010000, 16'd32);
        chk("R2 count too big", abort, 1);
        recover();
        chk("R8 cleared", abort, 0);
        // R2: count write to another sector aborts
        wr(1, 23'h010000, 16'h0025);
        wr(0, 23'h030000, 16'd1);
        chk("R2 count sector", abort, 1);
        // R8: broken sequence does not clear
        wr(0, 23'h000555, 16'h00AA);
        wr(0, 23'h0002AA, 16'h0055);
        wr(0, 23'h000555, 16'h00AA);
        wr(0, 23'h000555, 16'h00F0);
        chk("R8 broken seq", abort, 1);
        recover();
        chk("R8 cleared again", abort, 0);

        // R5: first load outside sector
        wr(1, 23'h010000, 16'h0025);
        wr(0, 23'h010000, 16'd0);
        wr(0, 23'h030000, 16'h1234);
        chk("R5 load sector", abort, 1);
        recover();

        // R7: wrong code after final load, and confirm to wrong sector
        wr(1, 23'h010000, 16'h0025);
        wr(0, 23'h010000, 16'd0);
        wr(0, 23'h010005, 16'h5A5A);
        wr(0, 23'h010000, 16'h0030);
        chk("R7 wrong code", abort, 1);
        recover();
        wr(1, 23'h010000, 16'h0025);
        wr(0, 23'h010000, 16'd0);
        wr(0, 23'h010005, 16'h5A5A);
        wr(0, 23'h030000, 16'h0029);
        chk("R7 wrong sector", abort, 1);
        recover();

        // R3: single-word load, upper data byte ignored in confirm
        wr(1, 23'h010000, 16'h0025);
        wr(0, 23'h010000, 16'd0);
        wr(0, 23'h010005, 16'h5A5A);
        wr(0, 23'h010000, 16'hFF29);
        chk("R6 start single", start, 1);
        chk("R3 single mask", mask, 64'h20);
        rd_idx = 5'd5; #1 chk("R6 slot5", rd_data, 16'h5A5A);
        finish_busy();

        // R1: reset clears an abort
        wr(1, 23'h010000, 16'h0025);
        wr(0, 23'h010000, 16'd40);
        chk("R1 pre abort", abort, 1);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); @(negedge clk);
        chk("R1 reset clears abort", abort, 0);
        rst_n = 1'b1;

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(20 * 100000);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog got=hang exp=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule